// File: doc/BRIEF.md
# Configurable GPIO Pin Controller

This block runs one general-purpose pin of a power-management controller. A four-bit function selector picks the signal the pin drives from a small set of internal sources: two sequenced external-enable bits, a supply-good flag, a converter-good flag, a 2 MHz clock and an auxiliary reset that depends on the current power state. The chosen logical level then passes through a polarity stage and a drive stage. The drive stage handles push-pull or open-drain drive, the direction setting, a per-pin enable that tri-states the pad, and the pull-resistor requests.

On the receive side, the pad level is synchronized and passed through the same polarity setting to give a conditioned input level. The block also detects edges and raises a one-cycle interrupt pulse on either the active edge or both edges. The active edge follows the polarity bit. Each pulse sets a sticky status bit, which software clears with a write-one-to-clear strobe.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: Function codes select the logical level: 4'hA external enable 1, 4'hB external enable 2, 4'hC supply good, 4'hD converter good, 4'hE gated clock, 4'hF auxiliary reset. Codes 4'h0 to 4'h9 give an inactive (0) logical level.
- R2: With `cfg_pol`=1 the driven level equals the logical level and `in_level` equals the synchronized pad. With `cfg_pol`=0 both are inverted.
- R3: With `cfg_ena`=0 the pin is tri-stated. In that state `pad_oe`, `pull_up_en`, `pull_dn_en` and `in_level` are 0, and pad activity raises no interrupt.
- R4: With `cfg_dir_out`=0 (input), `pad_oe` is 0 whatever the function code.
- R5: With `cfg_od`=1, `pad_out` is always 0 and `pad_oe` is 1 only when the driven level is 0. With `cfg_od`=0, `pad_oe` is 1 and `pad_out` equals the driven level.
- R6: Pull requests take effect only while the pin is enabled. If both pulls are requested, only the pull-down is applied.
- R7: Code 4'hE drives `src_clk2m` only while `src_ext_en1` or `src_ext_en2` is 1. Otherwise the logical level is 0.
- R8: Power state encoding: 2'b00 OFF, 2'b01 ON, 2'b10 SLEEP, 2'b11 transition. Code 4'hD gives `src_conv_ok` only in ON or SLEEP, and 0 in any other state.
- R9: Code 4'hF is 1 when `src_reset` is 1, or the state is OFF, or the state is SLEEP with `cfg_rst_in_sleep`=1. It is 0 otherwise.
- R10: A pad change driven before clock edge k appears on `in_level` after edge k+1, through a two-stage synchronizer.
- R11: With `cfg_irq_both`=0, `irq_pulse` fires on a rising pad edge when `cfg_pol`=1 and on a falling pad edge when `cfg_pol`=0. With `cfg_irq_both`=1 it fires on both edges. Each pulse lasts one cycle, between edges k+1 and k+2.
- R12: `irq_status` is set by `irq_pulse` and cleared by `irq_clr`. If both occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fn | input | 4 | Output function code |
| cfg_dir_out | input | 1 | 1 = output, 0 = input |
| cfg_pol | input | 1 | 1 = active high, 0 = active low |
| cfg_od | input | 1 | 1 = open-drain, 0 = push-pull |
| cfg_pu_req | input | 1 | Pull-up request |
| cfg_pd_req | input | 1 | Pull-down request |
| cfg_ena | input | 1 | Pin enable; 0 tri-states |
| cfg_irq_both | input | 1 | 1 = interrupt on both edges |
| cfg_rst_in_sleep | input | 1 | Auxiliary reset value in SLEEP |
| src_ext_en1 | input | 1 | Sequenced external enable 1 |
| src_ext_en2 | input | 1 | Sequenced external enable 2 |
| src_supply_ok | input | 1 | Supply-good flag |
| src_conv_ok | input | 1 | Converter-good flag |
| src_clk2m | input | 1 | 2 MHz clock source |
| src_reset | input | 1 | Internal reset flag |
| pwr_state | input | 2 | Current power state |
| pad_in | input | 1 | Pad input level |
| irq_clr | input | 1 | Write-one-to-clear strobe for status |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad output enable |
| pull_up_en | output | 1 | Pull-up enable |
| pull_dn_en | output | 1 | Pull-down enable |
| in_level | output | 1 | Conditioned input level |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_status | output | 1 | Sticky interrupt status |

## Verification
The hardest case to reach is a clear strobe arriving in the same cycle as a new interrupt pulse. Reaching it needs a pad edge placed exactly two clock edges ahead of the strobe. The bench counts those edges from a toggle driven at a falling clock edge, confirms that the pulse is present, and asserts `irq_clr` in that same cycle. Pulse counts taken over fixed windows show that each polarity and mode combination fires on the right edges only, and that a disabled pin ignores pad toggles.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  typedef enum logic [1:0] {
    PWR_OFF   = 2'b00,
    PWR_ON    = 2'b01,
    PWR_SLEEP = 2'b10,
    PWR_TRANS = 2'b11
  } pwr_state_e;

  localparam int FN_W = 4;

  localparam logic [FN_W-1:0] FN_EXT_EN1   = 4'hA;
  localparam logic [FN_W-1:0] FN_EXT_EN2   = 4'hB;
  localparam logic [FN_W-1:0] FN_SUPPLY_OK = 4'hC;
  localparam logic [FN_W-1:0] FN_CONV_OK   = 4'hD;
  localparam logic [FN_W-1:0] FN_CLK_OUT   = 4'hE;
  localparam logic [FN_W-1:0] FN_AUX_RST   = 4'hF;

endpackage

// File: rtl/gpio_fn_select.sv
module gpio_fn_select
  import gpio_pin_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FN_W-1:0] fn_sel,
  input  logic            ext_en1,
  input  logic            ext_en2,
  input  logic            supply_ok,
  input  logic            conv_ok,
  input  logic            clk2m,
  input  logic            reset_flag,
  input  logic [1:0]      pwr_state,
  input  logic            rst_in_sleep,
  output logic            fn_level
);

  pwr_state_e state;
  logic       conv_allowed;
  logic       aux_rst;
  logic       clk_gate;

  always_comb begin
    state        = pwr_state_e'(pwr_state);
    conv_allowed = (state == PWR_ON) || (state == PWR_SLEEP);
    clk_gate     = ext_en1 | ext_en2;
    aux_rst      = reset_flag
                 | (state == PWR_OFF)
                 | ((state == PWR_SLEEP) & rst_in_sleep);
  end

  always_comb begin
    case (fn_sel)
      FN_EXT_EN1:   fn_level = ext_en1;
      FN_EXT_EN2:   fn_level = ext_en2;
      FN_SUPPLY_OK: fn_level = supply_ok;
      FN_CONV_OK:   fn_level = conv_ok & conv_allowed;
      FN_CLK_OUT:   fn_level = clk2m & clk_gate;
      FN_AUX_RST:   fn_level = aux_rst;
      default:      fn_level = 1'b0;
    endcase
  end

  // R7: clock function stays low without an external enable
  assert_clk_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == FN_CLK_OUT && !ext_en1 && !ext_en2) |-> !fn_level);

  // R8: converter-good is suppressed outside ON and SLEEP
  assert_conv_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == FN_CONV_OK && pwr_state[1] == pwr_state[0]) |-> !fn_level);

  // R9: auxiliary reset always asserted in OFF
  assert_aux_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == FN_AUX_RST && pwr_state == 2'b00) |-> fn_level);

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic fn_level,
  input  logic pol,
  input  logic od,
  input  logic dir_out,
  input  logic ena,
  input  logic pu_req,
  input  logic pd_req,
  output logic pad_out,
  output logic pad_oe,
  output logic pu_en,
  output logic pd_en
);

  logic drive_level;
  logic drive_on;

  always_comb begin
    drive_level = pol ? fn_level : ~fn_level;
    drive_on    = ena & dir_out;
    if (od) begin
      pad_out = 1'b0;
      pad_oe  = drive_on & ~drive_level;
    end else begin
      pad_out = drive_level;
      pad_oe  = drive_on;
    end
    pu_en = ena & pu_req & ~pd_req;
    pd_en = ena & pd_req;
  end

  // R3: disabled pin neither drives nor pulls
  assert_tristate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |-> (!pad_oe && !pu_en && !pd_en));

  // R4: input direction never drives
  assert_input_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_out |-> !pad_oe);

  // R5: open-drain never drives a high level
  assert_od_low_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    od |-> !pad_out);

  // R6: pull-up and pull-down are never both on
  assert_pull_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pu_en, pd_en}) <= 1);

endmodule

// File: rtl/gpio_in_edge.sv
module gpio_in_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic ena,
  input  logic pol,
  input  logic irq_both,
  input  logic irq_clr,
  output logic in_level,
  output logic irq_pulse,
  output logic irq_status
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_d, sync_q;
  logic                   prev_d, prev_q;
  logic                   status_d, status_q;
  logic                   synced, rise, fall;

  // next-state for synchronizer chain, held while disabled
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_comb sync_d[g] = ena ? pad_in : sync_q[g];
    end else begin : g_rest
      always_comb sync_d[g] = ena ? sync_q[g-1] : sync_q[g];
    end
  end

  always_comb begin
    synced    = sync_q[LAST];
    prev_d    = ena ? synced : prev_q;
    rise      = synced & ~prev_q;
    fall      = ~synced & prev_q;
    irq_pulse = ena & (irq_both ? (rise | fall) : (pol ? rise : fall));
    if (irq_pulse)    status_d = 1'b1;
    else if (irq_clr) status_d = 1'b0;
    else              status_d = status_q;
    in_level   = ena & (pol ? synced : ~synced);
    irq_status = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      sync_q   <= sync_d;
      prev_q   <= prev_d;
      status_q <= status_d;
    end
  end

  // R12: a pulse always leaves the status set
  assert_status_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> irq_status);

  // R12: a clear without a competing pulse empties the status
  assert_status_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_pulse) |=> !irq_status);

  // R3: no interrupt and no level from a disabled pin
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |-> (!irq_pulse && !in_level));

  // R12: status only rises after a pulse
  assert_status_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status) |-> $past(irq_pulse));

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FN_W-1:0] cfg_fn,
  input  logic            cfg_dir_out,
  input  logic            cfg_pol,
  input  logic            cfg_od,
  input  logic            cfg_pu_req,
  input  logic            cfg_pd_req,
  input  logic            cfg_ena,
  input  logic            cfg_irq_both,
  input  logic            cfg_rst_in_sleep,
  input  logic            src_ext_en1,
  input  logic            src_ext_en2,
  input  logic            src_supply_ok,
  input  logic            src_conv_ok,
  input  logic            src_clk2m,
  input  logic            src_reset,
  input  logic [1:0]      pwr_state,
  input  logic            pad_in,
  input  logic            irq_clr,
  output logic            pad_out,
  output logic            pad_oe,
  output logic            pull_up_en,
  output logic            pull_dn_en,
  output logic            in_level,
  output logic            irq_pulse,
  output logic            irq_status
);

  logic fn_level;

  gpio_fn_select u_fn_select (
    .clk          (clk),
    .rst_n        (rst_n),
    .fn_sel       (cfg_fn),
    .ext_en1      (src_ext_en1),
    .ext_en2      (src_ext_en2),
    .supply_ok    (src_supply_ok),
    .conv_ok      (src_conv_ok),
    .clk2m        (src_clk2m),
    .reset_flag   (src_reset),
    .pwr_state    (pwr_state),
    .rst_in_sleep (cfg_rst_in_sleep),
    .fn_level     (fn_level)
  );

  gpio_pad_drive u_pad_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .fn_level (fn_level),
    .pol      (cfg_pol),
    .od       (cfg_od),
    .dir_out  (cfg_dir_out),
    .ena      (cfg_ena),
    .pu_req   (cfg_pu_req),
    .pd_req   (cfg_pd_req),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pu_en    (pull_up_en),
    .pd_en    (pull_dn_en)
  );

  gpio_in_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_in_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_in     (pad_in),
    .ena        (cfg_ena),
    .pol        (cfg_pol),
    .irq_both   (cfg_irq_both),
    .irq_clr    (irq_clr),
    .in_level   (in_level),
    .irq_pulse  (irq_pulse),
    .irq_status (irq_status)
  );

endmodule

// File: tb/gpio_pin_ctrl_tb.sv
module gpio_pin_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_fn;
  logic       cfg_dir_out, cfg_pol, cfg_od, cfg_pu_req, cfg_pd_req, cfg_ena;
  logic       cfg_irq_both, cfg_rst_in_sleep;
  logic       src_ext_en1, src_ext_en2, src_supply_ok, src_conv_ok, src_clk2m, src_reset;
  logic [1:0] pwr_state;
  logic       pad_in, irq_clr;
  logic       pad_out, pad_oe, pull_up_en, pull_dn_en, in_level, irq_pulse, irq_status;

  int checks = 0;
  int failures = 0;
  int pulse_cnt = 0;

  always #10 clk = ~clk;

  gpio_pin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fn(cfg_fn), .cfg_dir_out(cfg_dir_out),
    .cfg_pol(cfg_pol), .cfg_od(cfg_od), .cfg_pu_req(cfg_pu_req), .cfg_pd_req(cfg_pd_req),
    .cfg_ena(cfg_ena), .cfg_irq_both(cfg_irq_both), .cfg_rst_in_sleep(cfg_rst_in_sleep),
    .src_ext_en1(src_ext_en1), .src_ext_en2(src_ext_en2), .src_supply_ok(src_supply_ok),
    .src_conv_ok(src_conv_ok), .src_clk2m(src_clk2m), .src_reset(src_reset),
    .pwr_state(pwr_state), .pad_in(pad_in), .irq_clr(irq_clr),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
    .in_level(in_level), .irq_pulse(irq_pulse), .irq_status(irq_status)
  );

  always @(posedge clk) if (irq_pulse) pulse_cnt++;

  typedef struct packed {
    logic [3:0] fn;
    logic pol, od, dir, ena;
    logic en1, en2, sok, cok, ck, rst;
    logic [1:0] pwr;
    logic rsl;
    logic eo, eoe;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{4'hA,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b1,1'b1, 4'd1}, // R1
    '{4'hA,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b1, 4'd1}, // R1
    '{4'hB,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b1,1'b1, 4'd1}, // R1
    '{4'hC,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b1,1'b1, 4'd1}, // R1
    '{4'hD,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 2'b01,1'b0, 1'b1,1'b1, 4'd8}, // R8
    '{4'hD,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 2'b00,1'b0, 1'b0,1'b1, 4'd8}, // R8
    '{4'hD,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 2'b11,1'b0, 1'b0,1'b1, 4'd8}, // R8
    '{4'hD,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 2'b10,1'b0, 1'b1,1'b1, 4'd8}, // R8
    '{4'hE,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 2'b01,1'b0, 1'b1,1'b1, 4'd7}, // R7
    '{4'hE,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2'b01,1'b0, 1'b0,1'b1, 4'd7}, // R7
    '{4'hE,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'b01,1'b0, 1'b1,1'b1, 4'd7}, // R7
    '{4'hE,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b1, 4'd7}, // R7
    '{4'hF,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0, 1'b1,1'b1, 4'd9}, // R9
    '{4'hF,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b10,1'b0, 1'b0,1'b1, 4'd9}, // R9
    '{4'hF,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b10,1'b1, 1'b1,1'b1, 4'd9}, // R9
    '{4'hF,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'b01,1'b0, 1'b1,1'b1, 4'd9}, // R9
    '{4'hF,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b1, 4'd9}, // R9
    '{4'h3,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 2'b01,1'b1, 1'b0,1'b1, 4'd1}, // R1
    '{4'hA,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b1, 4'd2}, // R2
    '{4'hA,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b1,1'b1, 4'd2}, // R2
    '{4'hA,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b0, 4'd5}, // R5
    '{4'hA,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b1, 4'd5}, // R5
    '{4'hA,1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b0, 4'd5}, // R5
    '{4'hA,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b0, 4'd4}, // R4
    '{4'hA,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01,1'b0, 1'b0,1'b0, 4'd3}  // R3
  };

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_pulses(input logic val, input int exp, input string req);
    int start;
    start = pulse_cnt;
    @(negedge clk) pad_in = val;
    repeat (5) @(negedge clk);
    check(pulse_cnt - start == exp, req, "pulse count", pulse_cnt - start, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_fn = 4'h0; cfg_dir_out = 1'b1; cfg_pol = 1'b1; cfg_od = 1'b0;
    cfg_pu_req = 1'b0; cfg_pd_req = 1'b0; cfg_ena = 1'b1; cfg_irq_both = 1'b0;
    cfg_rst_in_sleep = 1'b0; src_ext_en1 = 1'b0; src_ext_en2 = 1'b0;
    src_supply_ok = 1'b0; src_conv_ok = 1'b0; src_clk2m = 1'b0; src_reset = 1'b0;
    pwr_state = 2'b01; pad_in = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_status == 1'b0, "R12", "reset status", irq_status, 0);
    check(in_level == 1'b0, "R10", "reset in_level", in_level, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // output path table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_fn = VECS[i].fn; cfg_pol = VECS[i].pol; cfg_od = VECS[i].od;
      cfg_dir_out = VECS[i].dir; cfg_ena = VECS[i].ena;
      src_ext_en1 = VECS[i].en1; src_ext_en2 = VECS[i].en2;
      src_supply_ok = VECS[i].sok; src_conv_ok = VECS[i].cok;
      src_clk2m = VECS[i].ck; src_reset = VECS[i].rst;
      pwr_state = VECS[i].pwr; cfg_rst_in_sleep = VECS[i].rsl;
      #2;
      check(pad_oe == VECS[i].eoe, $sformatf("R%0d", VECS[i].tag),
            $sformatf("vec %0d pad_oe", i), pad_oe, VECS[i].eoe);
      if (VECS[i].eoe || VECS[i].od)
        check(pad_out == VECS[i].eo, $sformatf("R%0d", VECS[i].tag),
              $sformatf("vec %0d pad_out", i), pad_out, VECS[i].eo);
    end

    // R6 pull handling
    @(negedge clk);
    cfg_fn = 4'h0; cfg_pol = 1'b1; cfg_od = 1'b0; cfg_dir_out = 1'b1; cfg_ena = 1'b1;
    cfg_pu_req = 1'b1; cfg_pd_req = 1'b0; #2;
    check(pull_up_en == 1'b1 && pull_dn_en == 1'b0, "R6", "pull-up only",
          {pull_up_en, pull_dn_en}, 2);
    cfg_pd_req = 1'b1; #2;
    check(pull_up_en == 1'b0 && pull_dn_en == 1'b1, "R6", "both requested",
          {pull_up_en, pull_dn_en}, 1);
    cfg_ena = 1'b0; #2;
    check(pull_up_en == 1'b0 && pull_dn_en == 1'b0, "R3", "pulls when disabled",
          {pull_up_en, pull_dn_en}, 0);
    cfg_ena = 1'b1; cfg_pu_req = 1'b0; cfg_pd_req = 1'b0;

    // R10 synchronizer latency
    @(negedge clk) pad_in = 1'b1;
    @(negedge clk);
    check(in_level == 1'b0, "R10", "in_level after one edge", in_level, 0);
    @(negedge clk);
    check(in_level == 1'b1, "R10", "in_level after two edges", in_level, 1);
    check(irq_pulse == 1'b1, "R11", "pulse on rising edge", irq_pulse, 1);
    @(negedge clk);
    check(irq_pulse == 1'b0, "R11", "pulse width one cycle", irq_pulse, 0);
    check(irq_status == 1'b1, "R12", "status set", irq_status, 1);
    cfg_pol = 1'b0; #2;
    check(in_level == 1'b0, "R2", "inverted input", in_level, 0);
    cfg_pol = 1'b1;

    // R12 clear
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    check(irq_status == 1'b0, "R12", "status cleared", irq_status, 0);

    // R11 edge selection
    expect_pulses(1'b0, 0, "R11 pol1 falling");
    expect_pulses(1'b1, 1, "R11 pol1 rising");
    cfg_pol = 1'b0;
    expect_pulses(1'b0, 1, "R11 pol0 falling");
    expect_pulses(1'b1, 0, "R11 pol0 rising");
    cfg_irq_both = 1'b1;
    expect_pulses(1'b0, 1, "R11 both falling");
    expect_pulses(1'b1, 1, "R11 both rising");

    // R12 set wins over clear in the same cycle
    @(negedge clk) pad_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(irq_pulse == 1'b1, "R12", "pulse present at collision", irq_pulse, 1);
    irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    check(irq_status == 1'b1, "R12", "set wins over clear", irq_status, 1);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;

    // R3 disabled pin ignores pad activity
    cfg_ena = 1'b0;
    expect_pulses(1'b1, 0, "R3 disabled rising");
    expect_pulses(1'b0, 0, "R3 disabled falling");
    check(in_level == 1'b0, "R3", "in_level disabled", in_level, 0);
    check(irq_status == 1'b0, "R3", "status untouched", irq_status, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule